// File: doc/BRIEF.md
# Gated IF Edge Counter with Status Pin Select

This block measures an intermediate-frequency signal by counting its rising edges over a gate window of selectable length. The window is timed from a 1 kHz timebase tick supplied from outside. A control bit arms the measurement. Raising it clears the count and starts a fixed settling wait. Then the gate window opens. When the window closes, the 20-bit result is frozen and a completion flag is set. The result can then be shifted out by a separate serial port.

The block also drives the pull-down enable of a shared open-drain status pin. A 3-bit mode field selects what the pin reports: loss of synthesizer lock, completion of the count, or detection of a stereo pilot. While the serial port is busy, the status drive is replaced by the serial port's own data. The IF input is asynchronous to the system clock. It is synchronised and edge-detected, so its frequency must stay below half the system clock rate.

Top module: `if_gate_counter`

## Requirements
- R1: After reset, `countVal` is 0, `countDone` is 0 and `doPullDown` is 0 (pin released).
- R2: While `cteBit` is 0, `countVal` is held at 0 and `countDone` is 0, whatever the other inputs do.
- R3: A 0-to-1 change of `cteBit` starts a settling wait that lasts exactly 4 `msTick` pulses (3 to 4 ms). IF edges seen before the fourth tick are not counted.
- R4: The gate window opens at the fourth tick after the start. It lasts `4 << gateSel` ticks: codes 0,1,2,3 give 4, 8, 16 and 32 ms. Every IF rising edge inside the window adds one to `countVal`.
- R5: Once the window has closed, `countVal` holds its value until `cteBit` falls. IF edges after the window have no effect.
- R6: The count saturates at its all-ones value (2^20−1 with default width) and does not wrap.
- R7: `countDone` rises on the tick that closes the window. It stays 0 during the wait and during the window.
- R8: With `ceHigh` at 0, `doPullDown` follows `doMode`. Mode 3'b001 gives `unlockDet`. Mode 3'b010 gives `countDone`. Mode 3'b110 gives `stereoDet`. Every other code gives 0.
- R9: While `ceHigh` is 1, `doPullDown` equals `serDataLow` regardless of `doMode`.
- R10: `gateSel` is captured when the measurement starts. Changing it during the wait or the window does not change the window length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ifIn | input | 1 | Asynchronous IF square wave to be counted |
| msTick | input | 1 | One-cycle pulse every 1 ms from the timebase |
| cteBit | input | 1 | 1 = run measurement, 0 = clear counter |
| gateSel | input | 2 | Gate window select (4/8/16/32 ms) |
| doMode | input | 3 | Status pin meaning select |
| unlockDet | input | 1 | Synthesizer unlock flag |
| stereoDet | input | 1 | Stereo pilot detected flag |
| ceHigh | input | 1 | Serial transfer in progress |
| serDataLow | input | 1 | Serial port pull-down request during transfer |
| countVal | output | 20 | Measured edge count |
| countDone | output | 1 | Measurement complete |
| doPullDown | output | 1 | Status pin pull-down enable |

## Verification
The embedded assertions check several properties on every cycle. The counter never wraps and never grows by more than one per cycle. It stays frozen outside the gate window. Completion can only come out of the gate window, and the window is only entered from the settling wait. A low control bit clears the completion flag, and the status pin is released in the unused modes. Some behaviour only the bench scenarios can show: that the window spans exactly the selected number of ticks, that edges in the wait are discarded, and that the captured gate select survives mid-measurement changes. The bench compares the exact count against a reference built from the random pulse counts it injected between ticks.

// File: rtl/if_gate_pkg.sv
package if_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_GATE,
    ST_DONE
  } measStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic clr;
    logic cntEn;
  } ctrlStrobeT;

  localparam logic [2:0] MODE_UNLOCK = 3'b001;
  localparam logic [2:0] MODE_ENDCNT = 3'b010;
  localparam logic [2:0] MODE_STEREO = 3'b110;

endpackage

// File: rtl/ifgc_ctrl.sv
module ifgc_ctrl
  import if_gate_pkg::*;
#(
  parameter int WAIT_TICKS = 4,
  parameter int BASE_GATE_TICKS = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msTick,
  input  logic             cteBit,
  input  logic [SEL_W-1:0] gateSel,
  input  logic [2:0]       doMode,
  input  logic             unlockDet,
  input  logic             stereoDet,
  input  logic             ceHigh,
  input  logic             serDataLow,
  output ctrlStrobeT       strb,
  output logic             countDone,
  output logic             doPullDown
);

  localparam int GATE_MAX = BASE_GATE_TICKS << ((1 << SEL_W) - 1);
  localparam int TICK_W = $clog2(GATE_MAX) + 1;
  localparam logic [TICK_W-1:0] WAIT_LAST = TICK_W'(WAIT_TICKS - 1);
  localparam logic [TICK_W-1:0] BASE_LEN = TICK_W'(BASE_GATE_TICKS);

  measStateT state;
  logic [TICK_W-1:0] tickCnt;
  logic [SEL_W-1:0] gateSelQ;
  logic cteQ;
  logic startPulse;
  logic [TICK_W-1:0] gateLast;

  assign startPulse = cteBit & ~cteQ;
  assign gateLast = (BASE_LEN << gateSelQ) - TICK_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      tickCnt <= '0;
      gateSelQ <= '0;
      cteQ <= 1'b0;
      countDone <= 1'b0;
    end else begin
      cteQ <= cteBit;
      if (!cteBit) begin
        state <= ST_IDLE;
        tickCnt <= '0;
        countDone <= 1'b0;
      end else if (startPulse) begin
        state <= ST_WAIT;
        tickCnt <= '0;
        gateSelQ <= gateSel;
        countDone <= 1'b0;
      end else begin
        case (state)
          ST_WAIT: if (msTick) begin
            if (tickCnt == WAIT_LAST) begin
              state <= ST_GATE;
              tickCnt <= '0;
            end else begin
              tickCnt <= tickCnt + TICK_W'(1);
            end
          end
          ST_GATE: if (msTick) begin
            if (tickCnt == gateLast) begin
              state <= ST_DONE;
              tickCnt <= '0;
              countDone <= 1'b1;
            end else begin
              tickCnt <= tickCnt + TICK_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    strb.clr = ~cteBit | startPulse;
    strb.cntEn = (state == ST_GATE);
  end

  always_comb begin
    if (ceHigh) begin
      doPullDown = serDataLow;
    end else begin
      case (doMode)
        MODE_UNLOCK: doPullDown = unlockDet;
        MODE_ENDCNT: doPullDown = countDone;
        MODE_STEREO: doPullDown = stereoDet;
        default:     doPullDown = 1'b0;
      endcase
    end
  end

  // R7: completion only comes out of the gate window
  a_r7_done_from_gate: assert property (@(posedge clk) disable iff (!rstN)
    $rose(countDone) |-> $past(state == ST_GATE));

  // R2: a low control bit clears completion on the next cycle
  a_r2_low_clears_done: assert property (@(posedge clk) disable iff (!rstN)
    !cteBit |=> !countDone);

  // R3: the gate window is entered only from the settling wait
  a_r3_wait_before_gate: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GATE && $past(state) != ST_GATE) |-> $past(state == ST_WAIT));

  // R8: unused modes release the pin
  a_r8_unused_mode_open: assert property (@(posedge clk) disable iff (!rstN)
    (!ceHigh && doMode != MODE_UNLOCK && doMode != MODE_ENDCNT && doMode != MODE_STEREO)
      |-> !doPullDown);

endmodule

// File: rtl/ifgc_datapath.sv
module ifgc_datapath
  import if_gate_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ifIn,
  input  ctrlStrobeT       strb,
  output logic [CNT_W-1:0] countVal
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [SYNC_STAGES:0] ifSync;
  logic ifRise;

  always_ff @(posedge clk) begin
    if (!rstN) ifSync <= '0;
    else       ifSync <= {ifSync[SYNC_STAGES-1:0], ifIn};
  end

  assign ifRise = ifSync[SYNC_STAGES-1] & ~ifSync[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strb.clr) begin
      countVal <= '0;
    end else if (strb.cntEn && ifRise && countVal != CNT_MAX) begin
      countVal <= countVal + CNT_W'(1);
    end
  end

  // R6: saturated count stays saturated
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (countVal == CNT_MAX && !strb.clr) |=> countVal == CNT_MAX);

  // R4: count advances by at most one per cycle
  a_r4_step_one: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clr |=> (countVal == $past(countVal) || countVal == $past(countVal) + CNT_W'(1)));

  // R5: outside the gate window the count is frozen
  a_r5_frozen_outside: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.clr && !strb.cntEn) |=> $stable(countVal));

endmodule

// File: rtl/if_gate_counter.sv
module if_gate_counter
  import if_gate_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int WAIT_TICKS = 4,
  parameter int BASE_GATE_TICKS = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ifIn,
  input  logic             msTick,
  input  logic             cteBit,
  input  logic [SEL_W-1:0] gateSel,
  input  logic [2:0]       doMode,
  input  logic             unlockDet,
  input  logic             stereoDet,
  input  logic             ceHigh,
  input  logic             serDataLow,
  output logic [CNT_W-1:0] countVal,
  output logic             countDone,
  output logic             doPullDown
);

  ctrlStrobeT strb;

  ifgc_ctrl #(
    .WAIT_TICKS(WAIT_TICKS),
    .BASE_GATE_TICKS(BASE_GATE_TICKS),
    .SEL_W(SEL_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .msTick(msTick), .cteBit(cteBit),
    .gateSel(gateSel), .doMode(doMode), .unlockDet(unlockDet),
    .stereoDet(stereoDet), .ceHigh(ceHigh), .serDataLow(serDataLow),
    .strb(strb), .countDone(countDone), .doPullDown(doPullDown)
  );

  ifgc_datapath #(
    .CNT_W(CNT_W),
    .SYNC_STAGES(2)
  ) i_dp (
    .clk(clk), .rstN(rstN), .ifIn(ifIn), .strb(strb), .countVal(countVal)
  );

endmodule

// File: tb/test_if_gate_counter.sv
module test_if_gate_counter;

  localparam int CLK_PER = 10;
  localparam int TICK_PER = 64;
  localparam int SAT_W = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ifIn = 1'b0;
  logic msTick = 1'b0;
  logic cteBit = 1'b0;
  logic [1:0] gateSel = 2'd0;
  logic [2:0] doMode = 3'd0;
  logic unlockDet = 1'b0;
  logic stereoDet = 1'b0;
  logic ceHigh = 1'b0;
  logic serDataLow = 1'b0;
  logic [19:0] countVal;
  logic countDone;
  logic doPullDown;
  logic [SAT_W-1:0] satVal;
  logic satDone;
  logic satDo;

  int total = 0;
  int bad = 0;

  always #(CLK_PER/2) clk = ~clk;

  if_gate_counter i_if_gate_counter (
    .clk(clk), .rstN(rstN), .ifIn(ifIn), .msTick(msTick), .cteBit(cteBit),
    .gateSel(gateSel), .doMode(doMode), .unlockDet(unlockDet),
    .stereoDet(stereoDet), .ceHigh(ceHigh), .serDataLow(serDataLow),
    .countVal(countVal), .countDone(countDone), .doPullDown(doPullDown)
  );

  if_gate_counter #(.CNT_W(SAT_W)) i_sat (
    .clk(clk), .rstN(rstN), .ifIn(ifIn), .msTick(msTick), .cteBit(cteBit),
    .gateSel(gateSel), .doMode(doMode), .unlockDet(unlockDet),
    .stereoDet(stereoDet), .ceHigh(ceHigh), .serDataLow(serDataLow),
    .countVal(satVal), .countDone(satDone), .doPullDown(satDo)
  );

  function automatic logic expDo(input logic [2:0] m, input logic unl, input logic st,
                                 input logic dn, input logic ce, input logic sd);
    if (ce) return sd;
    case (m)
      3'b001:  return unl;
      3'b010:  return dn;
      3'b110:  return st;
      default: return 1'b0;
    endcase
  endfunction

  function automatic int gateLen(input logic [1:0] s);
    return 4 << s;
  endfunction

  function automatic int satExp(input int e);
    return (e > (1 << SAT_W) - 1) ? (1 << SAT_W) - 1 : e;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic ifPulses(input int n);
    for (int k = 0; k < n; k++) begin
      ifIn = 1'b1; step(); step();
      ifIn = 1'b0; step(); step();
    end
  endtask

  // one interval: tick, then n IF pulses, then idle until next tick
  task automatic interval(input int n);
    msTick = 1'b1; step();
    msTick = 1'b0; step();
    ifPulses(n);
    for (int k = 0; k < TICK_PER - 2 - 4*n; k++) step();
  endtask

  task automatic measure(input logic [1:0] sel, input bit disturbSel);
    int expCnt = 0;
    int win = gateLen(sel);
    cteBit = 1'b0;
    ifPulses(3);
    step(); step();
    check("R2 count clear", countVal, 0);
    check("R2 done clear", countDone, 0);
    gateSel = sel;
    cteBit = 1'b1;
    step();
    if (disturbSel) gateSel = ~sel;
    ifPulses($urandom_range(0, 5));
    for (int i = 1; i <= 4 + win; i++) begin
      int n = $urandom_range(0, 10);
      if (i == 4 + win) n = 0;
      if (i == 3 + win && n == 0) n = 1;
      if (i >= 4 && i <= 3 + win) expCnt += n;
      interval(n);
      if (i == 2 + win) check("R7 done low in window", countDone, 0);
    end
    check(disturbSel ? "R10 window kept" : "R4 window count", countVal, expCnt);
    check("R7 done set", countDone, 1);
    check("R6 saturating count", satVal, satExp(expCnt));
    interval(6);
    interval(3);
    check("R5 count held", countVal, expCnt);
    check("R5 done held", countDone, 1);
  endtask

  initial begin
    #(CLK_PER * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    step(); step(); step();
    check("R1 count reset", countVal, 0);
    check("R1 done reset", countDone, 0);
    check("R1 pin reset", doPullDown, 0);
    rstN = 1'b1;
    step();
    check("R1 pin after reset", doPullDown, 0);

    // R3 + R4 directed: heavy edges during wait, shortest window
    measure(2'd0, 1'b0);
    measure(2'd1, 1'b0);
    measure(2'd2, 1'b0);
    measure(2'd3, 1'b0);
    // R10: gate select flipped right after the start
    measure(2'd0, 1'b1);
    measure(2'd1, 1'b1);

    // R8 / R9: all modes, done currently 1
    for (int pass = 0; pass < 2; pass++) begin
      for (int m = 0; m < 8; m++) begin
        for (int f = 0; f < 4; f++) begin
          doMode = 3'(m);
          unlockDet = f[0];
          stereoDet = f[1];
          ceHigh = 1'b0;
          serDataLow = 1'($urandom_range(0, 1));
          step();
          check("R8 status mode", doPullDown,
                expDo(doMode, unlockDet, stereoDet, countDone, 1'b0, serDataLow));
          ceHigh = 1'b1;
          step();
          check("R9 serial override", doPullDown, serDataLow);
          serDataLow = ~serDataLow;
          step();
          check("R9 serial override flip", doPullDown, serDataLow);
        end
      end
      // second pass with done cleared by a low control bit
      ceHigh = 1'b0;
      cteBit = 1'b0;
      step();
      check("R2 done cleared for pin", countDone, 0);
    end

    // end-of-count mode across a restart
    doMode = 3'b010;
    ceHigh = 1'b0;
    cteBit = 1'b1;
    step(); step();
    check("R8 end-of-count released on start", doPullDown, 0);

    // random measurements
    for (int r = 0; r < 3; r++) measure(2'($urandom_range(0, 2)), 1'($urandom_range(0, 1)));
    check("R8 end-of-count pulled after done", doPullDown, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule